// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block follows the power condition of a dual sampling converter from three inputs: the conversion-start strobe, a one-cycle pulse for each rising edge of the serial clock, and an active-low chip select. All three are taken as already synchronous to the system clock. The block counts serial-clock edges from each falling edge of the strobe. When the strobe rises again, that count decides what happened: an aborted start, a request to sleep, or a completed conversion.

A sleep request moves a running converter to partial power-down, where the reference stays on. A second sleep request moves it on to full power-down, where the reference is off. A completed conversion cycle brings it back. Raising chip select forces full power-down at once, and lowering it wakes the converter. Each wake from full power-down, and the period after reset, starts a settling timer of a parameter number of system clocks. Until the first completed conversion after reset, the controller stays in a calibration phase, and its results are not valid.

Top module: `power_mode_ctrl`

## Requirements
- R1: After reset, `mode` reads 3 (calibrating), `ref_on` is 1, `settle_busy` is 1 and `conv_ok` is 0. The mode codes are 0 running, 1 partial power-down, 2 full power-down and 3 calibrating.
- R2: While calibrating, a strobe rise that follows 14 or more serial-clock rising edges since the strobe fell moves the block to running (0). Rises that follow fewer edges leave it calibrating.
- R3: While running, a strobe rise that follows 3 to 13 edges moves the block to partial power-down (1), with `ref_on` still 1. Partial power-down is entered only from running.
- R4: A strobe rise that follows 0, 1 or 2 edges changes nothing in any mode.
- R5: In partial power-down, a strobe rise that follows 3 to 13 edges moves the block to full power-down (2), where `ref_on` and `settle_busy` are both 0. A rise that follows 3 to 13 edges while already in full power-down leaves it there.
- R6: From partial power-down, a rise that follows 14 or more edges returns the block to running with no settling wait: `settle_busy` stays 0 and `conv_ok` is 1.
- R7: From full power-down, a rise that follows 14 or more edges leaves the mode. `settle_busy` is then 1 for exactly SETTLE_CYCLES system clocks, beginning in the cycle the new mode appears.
- R8: While `cs_n` is 1, the mode is full power-down from the next cycle on, whatever the strobe does.
- R9: When `cs_n` returns to 0, the block leaves full power-down with the settling window of R7. It goes to running if a conversion has completed since reset, and to calibrating (3) otherwise.
- R10: `conv_ok` is 1 exactly when the mode is running and `settle_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_strobe | input | 1 | Conversion-start strobe; the falling edge starts a cycle |
| sclk_rise | input | 1 | One-cycle pulse per serial-clock rising edge |
| cs_n | input | 1 | Active-low chip select; high forces full power-down |
| mode | output | 2 | Power mode code (see R1) |
| ref_on | output | 1 | Reference enable |
| settle_busy | output | 1 | Reference settling timer is running |
| conv_ok | output | 1 | Conversions give valid results |

## Verification
A wrong mode register shows on `mode` and `ref_on` in the cycle after the strobe rise that caused it. A missed wake load shows as `settle_busy` low in that same cycle. A miscounted edge window shows only at the boundary counts 2/3 and 13/14, so both sides of each boundary are driven directly. A lost calibration flag stays hidden until a chip-select wake, when the block returns to the wrong mode. For that reason a chip-select cycle is run both before and after the first completed conversion.

// File: rtl/pm_pkg.sv
// Shared types for the power-mode controller.
// Assumes: all users import this package; codes of pm_mode_e are visible at the ports.
package pm_pkg;

    // Power condition of the converter, as reported on the mode port.
    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_PARTIAL = 2'd1,
        PM_FULL    = 2'd2,
        PM_CALIB   = 2'd3
    } pm_mode_e;

    // Meaning of a strobe release, judged by the edge count before it.
    typedef enum logic [1:0] {
        RC_NONE  = 2'd0,
        RC_ABORT = 2'd1,
        RC_SLEEP = 2'd2,
        RC_DONE  = 2'd3
    } rel_class_e;

endpackage

// File: rtl/pm_edge_window.sv
// Counts serial-clock rising edges since the last strobe fall and classifies
// each strobe rise into abort, sleep request or completed cycle.
// Assumes: strobe and sclk_rise are synchronous; a sclk_rise pulse in the same
// cycle as a strobe edge is not counted. The count saturates at DONE_MIN.
module pm_edge_window
    import pm_pkg::*;
#(
    parameter int PPD_MIN  = 3,
    parameter int DONE_MIN = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       sclk_rise,
    input  logic       cs_n,
    output rel_class_e rel_class
);
    localparam int CNT_W = $clog2(DONE_MIN + 1);
    localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(DONE_MIN);
    localparam logic [CNT_W-1:0] PPD_CNT  = CNT_W'(PPD_MIN);

    logic             strobe_q;
    logic [CNT_W-1:0] edge_cnt;
    logic             strobe_fall;
    logic             strobe_rise;

    assign strobe_fall = !strobe && strobe_q;
    assign strobe_rise = strobe && !strobe_q;

    // Delayed strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Saturating edge counter, cleared on strobe fall and while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       edge_cnt <= '0;
        else if (cs_n || strobe_fall)                     edge_cnt <= '0;
        else if (!strobe && sclk_rise && edge_cnt < DONE_CNT) edge_cnt <= edge_cnt + 1'b1;
    end

    // Classify a strobe rise; nothing is reported while deselected.
    always_comb begin
        rel_class = RC_NONE;
        if (!cs_n && strobe_rise) begin
            if (edge_cnt >= DONE_CNT)     rel_class = RC_DONE;
            else if (edge_cnt >= PPD_CNT) rel_class = RC_SLEEP;
            else                          rel_class = RC_ABORT;
        end
    end

endmodule

// File: rtl/pm_settle_timer.sv
// Down-counter for the reference settling wait; busy while nonzero.
// Assumes: load and hold_off are never both high; reset counts as a load.
module pm_settle_timer #(
    parameter int SETTLE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic hold_off,
    output logic busy
);
    localparam int T_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [T_W-1:0] LOAD_VAL = T_W'(SETTLE_CYCLES);

    logic [T_W-1:0] remain;

    // Load on reset or wake, clear while the reference is off, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= LOAD_VAL;
        else if (load)        remain <= LOAD_VAL;
        else if (hold_off)    remain <= '0;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/pm_mode_fsm.sv
// Power-mode state machine with the calibration-pending flag.
// Assumes: rel_class is RC_NONE whenever cs_n is high; cs_n is synchronous.
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  rel_class_e rel_class,
    output pm_mode_e   mode,
    output logic       wake_load,
    output logic       next_full
);
    pm_mode_e state_q, state_d;
    logic     cs_q;
    logic     cal_done;
    pm_mode_e wake_to;

    assign wake_to = cal_done ? PM_RUN : PM_CALIB;

    // Delayed chip select for deselect-release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_n;
    end

    // Next-state decision: chip select first, then strobe releases per mode.
    always_comb begin
        state_d   = state_q;
        wake_load = 1'b0;
        if (cs_n) begin
            state_d = PM_FULL;
        end else if (cs_q) begin
            state_d   = wake_to;
            wake_load = 1'b1;
        end else begin
            unique case (state_q)
                PM_CALIB:   if (rel_class == RC_DONE)  state_d = PM_RUN;
                PM_RUN:     if (rel_class == RC_SLEEP) state_d = PM_PARTIAL;
                PM_PARTIAL: begin
                    if (rel_class == RC_SLEEP)     state_d = PM_FULL;
                    else if (rel_class == RC_DONE) state_d = PM_RUN;
                end
                PM_FULL: begin
                    if (rel_class == RC_DONE) begin
                        state_d   = wake_to;
                        wake_load = 1'b1;
                    end
                end
                default: state_d = PM_CALIB;
            endcase
        end
    end

    assign next_full = (state_d == PM_FULL);

    // Mode register and calibration flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PM_CALIB;
            cal_done <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == PM_CALIB && rel_class == RC_DONE) cal_done <= 1'b1;
        end
    end

    assign mode = state_q;

endmodule

// File: rtl/power_mode_ctrl.sv
// Top of the converter power-mode controller: edge window, mode machine and
// settling timer. Assumes all inputs are synchronous to clk.
module power_mode_ctrl
    import pm_pkg::*;
#(
    parameter int PPD_MIN       = 3,
    parameter int DONE_MIN      = 14,
    parameter int SETTLE_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_strobe,
    input  logic       sclk_rise,
    input  logic       cs_n,
    output logic [1:0] mode,
    output logic       ref_on,
    output logic       settle_busy,
    output logic       conv_ok
);
    rel_class_e rel_class;
    pm_mode_e   mode_e;
    logic       wake_load;
    logic       next_full;

    pm_edge_window #(.PPD_MIN(PPD_MIN), .DONE_MIN(DONE_MIN)) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (conv_strobe),
        .sclk_rise (sclk_rise),
        .cs_n      (cs_n),
        .rel_class (rel_class)
    );

    pm_mode_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rel_class (rel_class),
        .mode      (mode_e),
        .wake_load (wake_load),
        .next_full (next_full)
    );

    pm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_load),
        .hold_off (next_full),
        .busy     (settle_busy)
    );

    assign mode    = mode_e;
    assign ref_on  = (mode_e != PM_FULL);
    assign conv_ok = (mode_e == PM_RUN) && !settle_busy;

endmodule

// File: rtl/pm_mode_chk.sv
// Port-level temporal checks for power_mode_ctrl, attached by bind.
module pm_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic [1:0] mode,
    input logic       settle_busy
);
    AST_CS_FORCES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (mode == 2'd2)); // R8
    AST_FULL_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> !settle_busy); // R5
    AST_WAKE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2 && $past(mode) == 2'd2) |-> settle_busy); // R7
    AST_PARTIAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) != 2'd1) |-> ($past(mode) == 2'd0)); // R3
    AST_CALIB_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) != 2'd3) |-> ($past(mode) == 2'd2)); // R9
    AST_BUSY_ONLY_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settle_busy) |-> ($past(mode) == 2'd2)); // R6
endmodule

bind power_mode_ctrl pm_mode_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .mode        (mode),
    .settle_busy (settle_busy)
);

// File: tb/power_mode_ctrl_tb_top.sv
module power_mode_ctrl_tb_top;
    localparam int S = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_strobe = 1'b1;
    logic       sclk_rise = 1'b0;
    logic       cs_n = 1'b0;
    logic [1:0] mode;
    logic       ref_on, settle_busy, conv_ok;

    int errors = 0;
    int checks = 0;
    logic [1:0] exp_mode;
    bit         exp_cal;
    bit         finished = 0;

    power_mode_ctrl #(.SETTLE_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .sclk_rise(sclk_rise),
        .cs_n(cs_n), .mode(mode), .ref_on(ref_on), .settle_busy(settle_busy), .conv_ok(conv_ok)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 1 abort, 2 sleep, 3 done
    function automatic int classify(input int e);
        if (e < 3)  return 1;
        if (e < 14) return 2;
        return 3;
    endfunction

    function automatic logic [1:0] next_mode(input logic [1:0] m, input bit cal, input int c);
        case (m)
            2'd3: return (c == 3) ? 2'd0 : 2'd3;
            2'd0: return (c == 2) ? 2'd1 : 2'd0;
            2'd1: return (c == 2) ? 2'd2 : (c == 3) ? 2'd0 : 2'd1;
            default: return (c == 3) ? (cal ? 2'd0 : 2'd3) : 2'd2;
        endcase
    endfunction

    // Check mode, reference and the settling window after a transition.
    task automatic check_after(input bit wake, input string req);
        check(mode == exp_mode, req, mode, exp_mode);
        check(ref_on == (exp_mode != 2'd2), req, ref_on, exp_mode != 2'd2);
        if (wake) begin
            check(settle_busy == 1'b1, req, settle_busy, 1);
            repeat (S - 1) @(negedge clk);
            check(settle_busy == 1'b1, req, settle_busy, 1);
            @(negedge clk);
            check(settle_busy == 1'b0, req, settle_busy, 0);
        end else begin
            check(settle_busy == 1'b0, req, settle_busy, 0);
        end
        check(conv_ok == (exp_mode == 2'd0), {req, " R10"}, conv_ok, exp_mode == 2'd0);
    endtask

    task automatic do_seq(input int edges, input string req);
        int  c;
        bit  wake;
        @(negedge clk) conv_strobe = 1'b0;
        @(negedge clk);
        for (int i = 0; i < edges; i++) begin
            sclk_rise = 1'b1;
            @(negedge clk) sclk_rise = 1'b0;
            @(negedge clk);
        end
        conv_strobe = 1'b1;
        c    = classify(edges);
        wake = (exp_mode == 2'd2) && (c == 3);
        if (exp_mode == 2'd3 && c == 3) exp_cal = 1'b1;
        exp_mode = next_mode(exp_mode, exp_cal, c);
        @(negedge clk);
        check_after(wake, req);
    endtask

    task automatic do_cs(input string req);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        exp_mode = 2'd2;
        check(mode == 2'd2, {req, " R8"}, mode, 2);
        check(ref_on == 1'b0, {req, " R8"}, ref_on, 0);
        conv_strobe = 1'b0;
        for (int i = 0; i < 16; i++) begin
            sclk_rise = 1'b1;
            @(negedge clk) sclk_rise = 1'b0;
            @(negedge clk);
        end
        conv_strobe = 1'b1;
        @(negedge clk);
        check(mode == 2'd2, {req, " R8 strobe ignored"}, mode, 2);
        cs_n = 1'b0;
        exp_mode = exp_cal ? 2'd0 : 2'd3;
        @(negedge clk);
        check_after(1'b1, {req, " R9"});
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_mode = 2'd3;
        exp_cal  = 1'b0;
        @(negedge clk);
        check(mode == 2'd3, "R1 mode", mode, 3);
        check(ref_on == 1'b1, "R1 ref", ref_on, 1);
        check(settle_busy == 1'b1, "R1 busy", settle_busy, 1);
        check(conv_ok == 1'b0, "R1 ok", conv_ok, 0);
        repeat (S + 2) @(negedge clk);
        check(settle_busy == 1'b0, "R1 settle end", settle_busy, 0);

        do_seq(8,  "R2 short in calib");
        do_seq(2,  "R4 abort in calib");
        do_cs("R9 wake before calib");
        do_seq(14, "R2 calibrate");
        do_seq(2,  "R4 abort in run");
        do_seq(13, "R3 upper window");
        do_seq(2,  "R4 abort in partial");
        do_seq(3,  "R5 lower window");
        do_seq(5,  "R5 sleep in full");
        do_seq(14, "R7 wake by cycle");
        do_seq(3,  "R3 lower window");
        do_seq(20, "R6 exit partial");
        do_cs("R9 wake after calib");

        for (int n = 0; n < 80; n++) begin
            int unsigned pick;
            pick = $urandom_range(9, 0);
            if (pick == 0) do_cs("R8 random");
            else           do_seq(int'($urandom_range(18, 0)), "R7 random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule